// File: doc/BRIEF.md
# Tagged Fan-In Compute Pipeline with Routed Fan-Out

This block lets several independent producers share one compute pipeline. Each producer has its own valid/ready input port and offers a pair of operands. A round-robin arbiter admits at most one pair per cycle. The fabric stamps the admitted item with the number of the port that accepted it.

The item then passes through three register stages. A 32-bit sum is formed across the second and third stages: the lower half and its carry first, then the upper half. The stamp travels with the item unchanged. At the exit, the stamp alone chooses the consumer port with the same index. That port raises its valid; every other output port stays idle with zeroed data.

If the chosen consumer is not ready, every stage holds and no new item is admitted. Head-of-line blocking is an accepted cost of this design. The port count must be a power of two.

Top module: `tag_route_pipe`

## Requirements
- R1: While rst_ni is low, every in_ready_o bit and every out_valid_o bit is 0, even when producers and consumers are active.
- R2: in_ready_o has at most one bit set, and a bit is set only for a port whose in_valid_i is high.
- R3: Admission is round-robin. After port g is granted, the next grant goes to the first requesting port found in the order g+1, g+2, … (mod 4). After reset, port 0 has first priority.
- R4: The tag carried by an item is the index of the input port that accepted it, and out_mid_o of the emitting port equals that index.
- R5: A result is shown only on the output port whose index equals its tag. All other ports have out_valid_o 0 and out_z_o and out_mid_o equal to 0.
- R6: out_z_o equals (a + b) mod 2^32, including sums that carry across the 16-bit half boundary and sums that overflow 32 bits.
- R7: With no stall, a result becomes valid in the third cycle after the cycle in which its operands were accepted.
- R8: While a valid stage-3 result faces a low out_ready_i on its port, all stages hold their contents, the output stays stable, and in_ready_o is all zero.
- R9: Every accepted item leaves exactly once. For each port, results leave in the order the operands were accepted, under random producer gaps and random consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 4 | Per-port operand valid |
| in_a_i | input | 4x32 | Per-port first operand |
| in_b_i | input | 4x32 | Per-port second operand |
| in_ready_o | output | 4 | Per-port accept strobe |
| out_valid_o | output | 4 | Per-port result valid |
| out_z_o | output | 4x32 | Per-port result, zero when idle |
| out_mid_o | output | 4x2 | Per-port tag of the shown result |
| out_ready_i | input | 4 | Per-port consumer ready |

## Verification
Admission of a new item at the head of the pipeline can fall in the same cycle as retirement of the stage-3 result, or as a stall caused by that result's consumer. Both reduce to one shared advance condition. To provoke every mix of these, all four producers are kept saturated while each consumer's ready is toggled randomly. A forced window with all consumers blocked is added. A behavioural model with its own queues predicts grants, valids, tags and sums. The bench compares against it on every clock, and it checks the per-port order at each retirement.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int unsigned PORTS_DEF = 4;
  localparam int unsigned WIDTH_DEF = 32;
endpackage

// File: rtl/trp_rr_arb.sv
module trp_rr_arb #(
  parameter int unsigned N  = trp_pkg::PORTS_DEF,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          en_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] cand;
  logic          hit;

  always_comb begin
    hit   = 1'b0;
    idx_o = '0;
    cand  = '0;
    for (int k = 0; k < N; k++) begin
      cand = ptr_q + IW'(k);
      if (!hit && req_i[cand]) begin
        hit   = 1'b1;
        idx_o = cand;
      end
    end
    gnt_o = (hit && en_i) ? (N'(1) << idx_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_q <= '0;
    else if (hit && en_i)   ptr_q <= idx_o + IW'(1);
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R2
  AST_GNT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R2
endmodule

// File: rtl/trp_stage.sv
module trp_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          vld_i,
  input  logic [DW-1:0] dat_i,
  output logic          vld_o,
  output logic [DW-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else if (en_i) begin
      vld_o <= vld_i;
      dat_o <= dat_i;
    end
  end
endmodule

// File: rtl/tag_route_pipe.sv
module tag_route_pipe #(
  parameter int unsigned N = trp_pkg::PORTS_DEF,
  parameter int unsigned W = trp_pkg::WIDTH_DEF,
  localparam int unsigned TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         in_valid_i,
  input  logic [N-1:0][W-1:0]  in_a_i,
  input  logic [N-1:0][W-1:0]  in_b_i,
  output logic [N-1:0]         in_ready_o,
  output logic [N-1:0]         out_valid_o,
  output logic [N-1:0][W-1:0]  out_z_o,
  output logic [N-1:0][TW-1:0] out_mid_o,
  input  logic [N-1:0]         out_ready_i
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned HW = W - H;
  localparam int unsigned D1 = TW + 2 * W;
  localparam int unsigned D2 = TW + H + 1 + 2 * HW;
  localparam int unsigned D3 = TW + W;

  logic          adv;
  logic [N-1:0]  gnt;
  logic [TW-1:0] gidx;

  logic          s1_v, s2_v, s3_v;
  logic [D1-1:0] s1_q;
  logic [D2-1:0] s2_d, s2_q;
  logic [D3-1:0] s3_d, s3_q;

  logic [TW-1:0] s1_tag, s2_tag, s3_tag;
  logic [W-1:0]  s1_a, s1_b, s3_z;
  logic [H:0]    lo_sum, s2_lo;
  logic [HW-1:0] s2_ahi, s2_bhi, hi_sum;

  // global advance: any stall at the exit freezes every stage
  assign adv = !s3_v || out_ready_i[s3_tag];

  trp_rr_arb #(.N(N)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (in_valid_i),
    .en_i  (adv),
    .gnt_o (gnt),
    .idx_o (gidx)
  );

  assign in_ready_o = gnt & {N{rst_ni}};

  trp_stage #(.DW(D1)) u_s1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(adv),
    .vld_i(|gnt), .dat_i({gidx, in_a_i[gidx], in_b_i[gidx]}),
    .vld_o(s1_v), .dat_o(s1_q)
  );

  assign s1_tag = s1_q[D1-1 -: TW];
  assign s1_a   = s1_q[2*W-1 -: W];
  assign s1_b   = s1_q[W-1:0];
  assign lo_sum = {1'b0, s1_a[H-1:0]} + {1'b0, s1_b[H-1:0]};
  assign s2_d   = {s1_tag, lo_sum, s1_a[W-1:H], s1_b[W-1:H]};

  trp_stage #(.DW(D2)) u_s2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(adv),
    .vld_i(s1_v), .dat_i(s2_d),
    .vld_o(s2_v), .dat_o(s2_q)
  );

  assign s2_bhi = s2_q[HW-1:0];
  assign s2_ahi = s2_q[2*HW-1 -: HW];
  assign s2_lo  = s2_q[2*HW+H -: H+1];
  assign s2_tag = s2_q[D2-1 -: TW];
  assign hi_sum = s2_ahi + s2_bhi + HW'(s2_lo[H]);
  assign s3_d   = {s2_tag, hi_sum, s2_lo[H-1:0]};

  trp_stage #(.DW(D3)) u_s3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(adv),
    .vld_i(s2_v), .dat_i(s3_d),
    .vld_o(s3_v), .dat_o(s3_q)
  );

  assign s3_tag = s3_q[D3-1 -: TW];
  assign s3_z   = s3_q[W-1:0];

  for (genvar n = 0; n < N; n++) begin : g_out
    logic hit;
    assign hit            = s3_v && (s3_tag == TW'(n));
    assign out_valid_o[n] = hit;
    assign out_z_o[n]     = hit ? s3_z : '0;
    assign out_mid_o[n]   = hit ? s3_tag : '0;

    AST_MID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[n] |-> out_mid_o[n] == TW'(n)); // R4
  end

  AST_OUT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid_o)); // R5
  AST_IN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_ready_o)); // R2
  AST_STALL_NO_ADMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(out_valid_o & ~out_ready_i)) |-> in_ready_o == '0); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(out_valid_o & ~out_ready_i)) |=> $stable(out_valid_o) && $stable(out_z_o)); // R8
endmodule

// File: tb/sim_tag_route_pipe.sv
`timescale 1ns/1ps
module sim_tag_route_pipe;
  localparam int N = 4;
  localparam int ITEMS = 60;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]        in_valid;
  logic [N-1:0][31:0]  in_a, in_b;
  logic [N-1:0]        in_ready;
  logic [N-1:0]        out_valid;
  logic [N-1:0][31:0]  out_z;
  logic [N-1:0][1:0]   out_mid;
  logic [N-1:0]        out_ready;

  always #5 clk = ~clk;

  tag_route_pipe u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_a_i(in_a), .in_b_i(in_b), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_z_o(out_z), .out_mid_o(out_mid),
    .out_ready_i(out_ready)
  );

  int checks = 0, failures = 0;
  int sent [N], rcvd [N];
  bit pend [N];
  logic [31:0] pa [N], pb [N];
  logic [31:0] exp_q [N][$];
  int ptr;
  bit mv [3];
  int mtag [3];
  logic [31:0] mres [3];
  int send_pct, ready_pct;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit adv;
    int g;
    logic [N-1:0] exp_rdy, exp_vld;
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      if (!pend[p] && sent[p] < ITEMS && $urandom_range(99) < send_pct) begin
        pend[p] = 1'b1;
        if (sent[p] == 0 && p == 0) begin pa[p] = 32'hFFFF_FFFF; pb[p] = 32'h1; end
        else if (sent[p] == 0 && p == 1) begin pa[p] = 32'h0000_FFFF; pb[p] = 32'h1; end
        else if (sent[p] == 1) begin pa[p] = 32'hFFFF_0000; pb[p] = 32'h0003_0000; end
        else begin pa[p] = $urandom; pb[p] = $urandom; end
        sent[p]++;
      end
      in_valid[p] = pend[p];
      in_a[p] = pend[p] ? pa[p] : $urandom;
      in_b[p] = pend[p] ? pb[p] : $urandom;
      out_ready[p] = ($urandom_range(99) < ready_pct);
    end
    #1;
    adv = !mv[2] || out_ready[mtag[2]];
    g = -1;
    if (adv)
      for (int k = 0; k < N; k++)
        if (g < 0 && pend[(ptr + k) % N]) g = (ptr + k) % N;
    exp_rdy = (g >= 0) ? (4'b1 << g) : '0;
    exp_vld = mv[2] ? (4'b1 << mtag[2]) : '0;
    if (!adv) chk(in_ready == 0, "R8 admit during stall", in_ready, 0);
    else      chk(in_ready == exp_rdy, "R2/R3 grant", in_ready, exp_rdy);
    chk(out_valid == exp_vld, "R5/R7 valid", out_valid, exp_vld);
    for (int p = 0; p < N; p++) begin
      if (mv[2] && p == mtag[2]) begin
        chk(out_mid[p] == 2'(p), "R4 tag", out_mid[p], p);
        chk(out_z[p] == mres[2], "R6 sum", out_z[p], mres[2]);
      end else begin
        chk(out_z[p] == 0 && out_mid[p] == 0, "R5 idle port data", out_z[p], 0);
      end
    end
    if (mv[2] && out_ready[mtag[2]]) begin
      if (exp_q[mtag[2]].size() == 0) chk(1'b0, "R9 duplicate", out_z[mtag[2]], 0);
      else begin
        logic [31:0] e;
        e = exp_q[mtag[2]].pop_front();
        chk(out_z[mtag[2]] == e, "R9 order", out_z[mtag[2]], e);
      end
      rcvd[mtag[2]]++;
    end
    if (adv) begin
      mv[2] = mv[1]; mtag[2] = mtag[1]; mres[2] = mres[1];
      mv[1] = mv[0]; mtag[1] = mtag[0]; mres[1] = mres[0];
      mv[0] = (g >= 0);
      if (g >= 0) begin
        mtag[0] = g;
        mres[0] = pa[g] + pb[g];
        exp_q[g].push_back(pa[g] + pb[g]);
        ptr = (g + 1) % N;
        pend[g] = 1'b0;
      end
    end
  endtask

  initial begin
    int cyc;
    bit done;
    ptr = 0;
    for (int i = 0; i < 3; i++) begin mv[i] = 0; mtag[i] = 0; mres[i] = 0; end
    for (int p = 0; p < N; p++) begin sent[p] = 0; rcvd[p] = 0; pend[p] = 0; end
    in_valid = '1; in_a = '0; in_b = '0; out_ready = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 0, "R1 ready in reset", in_ready, 0);
      chk(out_valid == 0, "R1 valid in reset", out_valid, 0);
    end
    in_valid = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    cyc = 0;
    done = 0;
    while (!done && cyc < LIMIT) begin
      if (cyc < 200)                    begin send_pct = 100; ready_pct = 100; end
      else if (cyc >= 300 && cyc < 325) begin send_pct = 100; ready_pct = 0;   end
      else if (cyc < 600)               begin send_pct = 100; ready_pct = 60;  end
      else                              begin send_pct = 40;  ready_pct = 70;  end
      step();
      cyc++;
      done = 1;
      for (int p = 0; p < N; p++) if (rcvd[p] < ITEMS) done = 0;
    end
    if (!done) chk(1'b0, "R9 watchdog expired", cyc, LIMIT);
    for (int p = 0; p < N; p++) begin
      chk(rcvd[p] == ITEMS, "R9 count per port", rcvd[p], ITEMS);
      chk(exp_q[p].size() == 0, "R9 nothing left", exp_q[p].size(), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule